// File: doc/BRIEF.md
# Compare and Capture Up-Counter Timer

This block is a 32-bit timer peripheral for a processor subsystem. Software programs it through a small register port: one address, write data, a write strobe and a read strobe. An optional prescaler divides the count source. The up-counter behind it serves two purposes. Software can read it directly as a timestamp that wraps around, and it can act as a one-shot or repeating event source through a compare register.

A control bit picks how the counter behaves at a compare match. In free-running mode it carries on through the match, so software can arm the next event relative to the current count. In restart mode it returns to zero after it has held the compare value for one count period. A capture input copies the count on each rising edge. Compare and capture events each set their own sticky status flag, and software clears a flag by writing a one to it. The interrupt line reports either flag when interrupts are enabled.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads as zero and `irq` is low.
- R2: With control bit 0 (enable) set and control bit 1 (source select) set, the counter advances once per clock. With bit 1 clear, it advances only on clocks where `extTick` is high. With bit 0 clear, it never advances.
- R3: With a prescaler value p at offset 0x04, the counter advances once every p+1 count-source ticks. p = 0 means every tick.
- R4: Any write to control (offset 0x00) with bit 0 clear resets the counter and the prescaler phase to zero, so counting restarts from zero when the timer is enabled again.
- R5: The compare flag (status bit 0) is set on the clock edge at which the counter steps onto the value in the compare register (offset 0x08).
- R6: With control bit 8 set (free-run), the counter keeps incrementing past the match. A compare value below the current count produces no event until the counter wraps.
- R7: With control bit 8 clear (restart), the counter holds the compare value for one count period and then reloads to zero.
- R8: A rising edge on `capIn` copies the count from before that edge into the capture register (offset 0x0C, read-only; writes are ignored) and sets status bit 1. Holding `capIn` high does not capture again.
- R9: Writing the status register (offset 0x14) clears each flag whose data bit is one and leaves flags whose data bit is zero unchanged.
- R10: `irq` is high exactly when control bit 4 is set and at least one status flag is set.
- R11: The counter reads at offset 0x10. `rdData` is the selected register while `rdEn` is high. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W (5) | Register byte offset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | DATA_W (32) | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | DATA_W (32) | Read data, combinational from addr when rdEn is high |
| extTick | input | 1 | Alternative count source, sampled each clock |
| capIn | input | 1 | Capture trigger, synchronous to clk |
| irq | output | 1 | Level interrupt |

## Verification
The checker evaluates several properties on every cycle. The counter never jumps by more than one while it runs free. It stays at zero whenever the timer is disabled. A newly set compare flag matches the count against the compare register, and a newly set capture flag matches the captured value against the count from the edge before. The interrupt is never high while interrupts are disabled. Other behaviours can only be shown by the bench scenarios: the exact prescaled step rate, the restart sequence that holds the compare value and then returns to zero, the external tick source, clearing by writing ones while zero bits are ignored, the read-only capture register, and the absence of an event when the compare value lies below the count.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // Register byte offsets; software decodes these
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_PRE  = 'h04;
  localparam int OFS_CMP  = 'h08;
  localparam int OFS_CAP  = 'h0C;
  localparam int OFS_CNT  = 'h10;
  localparam int OFS_STAT = 'h14;

  // Control bit positions
  localparam int CB_EN   = 0;
  localparam int CB_SRC  = 1;
  localparam int CB_IRQ  = 4;
  localparam int CB_FREE = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic clear;
    logic freeRun;
  } dpCtl_t;
endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [DATA_W-1:0] prescale,
  input  logic [DATA_W-1:0] compare,
  input  logic              capIn,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] capVal,
  output logic              cmpHit,
  output logic              capHit
);
  logic [DATA_W-1:0] preCnt;
  logic [DATA_W-1:0] nextCount;
  logic              capPrev;
  logic              phaseEnd;
  logic              step;

  always_comb begin
    phaseEnd  = (preCnt >= prescale);
    step      = dpCtl.tick && phaseEnd && !dpCtl.clear;
    nextCount = (!dpCtl.freeRun && (count == compare)) ? '0 : count + 1'b1;
    cmpHit    = step && (nextCount == compare);
    capHit    = capIn && !capPrev;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      count   <= '0;
      capPrev <= 1'b0;
      capVal  <= '0;
    end else begin
      capPrev <= capIn;
      if (capHit) capVal <= count;
      if (dpCtl.clear) begin
        preCnt <= '0;
        count  <= '0;
      end else if (dpCtl.tick) begin
        preCnt <= phaseEnd ? '0 : preCnt + 1'b1;
        if (step) count <= nextCount;
      end
    end
  end
endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              extTick,
  input  logic [DATA_W-1:0] count,
  input  logic [DATA_W-1:0] capVal,
  input  logic              cmpHit,
  input  logic              capHit,
  output dpCtl_t            dpCtl,
  output logic [DATA_W-1:0] prescale,
  output logic [DATA_W-1:0] compare,
  output logic [DATA_W-1:0] ctrlWord,
  output logic              cmpFlag,
  output logic              capFlag,
  output logic              irq
);
  logic wrCtrl, wrPre, wrCmp, wrStat;

  always_comb begin
    wrCtrl = wrEn && (addr == ADDR_W'(OFS_CTRL));
    wrPre  = wrEn && (addr == ADDR_W'(OFS_PRE));
    wrCmp  = wrEn && (addr == ADDR_W'(OFS_CMP));
    wrStat = wrEn && (addr == ADDR_W'(OFS_STAT));
    dpCtl.clear   = wrCtrl && !wrData[CB_EN];
    dpCtl.tick    = ctrlWord[CB_EN] && (ctrlWord[CB_SRC] || extTick);
    dpCtl.freeRun = ctrlWord[CB_FREE];
    irq = ctrlWord[CB_IRQ] && (cmpFlag || capFlag);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlWord <= '0;
      prescale <= '0;
      compare  <= '0;
      cmpFlag  <= 1'b0;
      capFlag  <= 1'b0;
    end else begin
      if (wrCtrl) ctrlWord <= wrData;
      if (wrPre)  prescale <= wrData;
      if (wrCmp)  compare  <= wrData;
      // a new event wins over a simultaneous clear
      cmpFlag <= cmpHit || (cmpFlag && !(wrStat && wrData[0]));
      capFlag <= capHit || (capFlag && !(wrStat && wrData[1]));
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (addr == ADDR_W'(OFS_CTRL))      rdData = ctrlWord;
      else if (addr == ADDR_W'(OFS_PRE))  rdData = prescale;
      else if (addr == ADDR_W'(OFS_CMP))  rdData = compare;
      else if (addr == ADDR_W'(OFS_CAP))  rdData = capVal;
      else if (addr == ADDR_W'(OFS_CNT))  rdData = count;
      else if (addr == ADDR_W'(OFS_STAT)) rdData = DATA_W'({capFlag, cmpFlag});
    end
  end
endmodule

// File: rtl/match_timer.sv
module match_timer
  import timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              extTick,
  input  logic              capIn,
  output logic              irq
);
  dpCtl_t            dpCtl;
  logic [DATA_W-1:0] prescale, compare, count, capVal, ctrlWord;
  logic              cmpHit, capHit, cmpFlag, capFlag;

  timer_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .extTick(extTick), .count(count),
    .capVal(capVal), .cmpHit(cmpHit), .capHit(capHit), .dpCtl(dpCtl),
    .prescale(prescale), .compare(compare), .ctrlWord(ctrlWord),
    .cmpFlag(cmpFlag), .capFlag(capFlag), .irq(irq)
  );

  timer_datapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .prescale(prescale),
    .compare(compare), .capIn(capIn), .count(count), .capVal(capVal),
    .cmpHit(cmpHit), .capHit(capHit)
  );
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] ctrlWord,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] compare,
  input logic [DATA_W-1:0] capVal,
  input logic              cmpFlag,
  input logic              capFlag,
  input logic              irq
);
  AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctrlWord[0]) && $past(ctrlWord[8]) && !$past(wrEn))
      |-> (count == $past(count) || count == $past(count) + 1'b1)); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWord[0] |-> (count == '0)); // R4
  AST_CMP_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cmpFlag) && !$past(wrEn)) |-> (count == compare)); // R5
  AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(capFlag) |-> (capVal == $past(count))); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ctrlWord[4]); // R10
endmodule

bind match_timer match_timer_chk #(.DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .ctrlWord(ctrlWord), .count(count),
  .compare(compare), .capVal(capVal), .cmpFlag(cmpFlag), .capFlag(capFlag),
  .irq(irq)
);

// File: tb/match_timer_test.sv
module match_timer_test;
  localparam int DW = 32;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0, extTick = 1'b0, capIn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic irq;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [DW-1:0] data;
    logic          irqExp;
    string         tag;
  } item_t;
  item_t expQ[$];

  always #4 clk = ~clk;

  match_timer #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .extTick(extTick), .capIn(capIn), .irq(irq)
  );

  // monitor: compares each read against the queued expectation
  always begin
    @(negedge clk);
    #2;
    if (rdEn) begin
      item_t it;
      it = expQ.pop_front();
      checks++;
      if (rdData !== it.data || irq !== it.irqExp) begin
        errors++;
        $display("FAIL %s: rdData=%h irq=%b expected rdData=%h irq=%b",
                 it.tag, rdData, irq, it.data, it.irqExp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic ie, input string tag);
    item_t it;
    it.data = d; it.irqExp = ie; it.tag = tag;
    expQ.push_back(it);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    rd('h00, 0, 0, "R1 ctrl");
    rd('h10, 0, 0, "R1 count");
    rd('h14, 0, 0, "R1 status");
    rd('h0C, 0, 0, "R1 capture");
    // R2 bus-clock counting
    wr('h00, 'h103);
    rd('h10, 0, 0, "R2 count start");
    idle(7);
    rd('h10, 8, 0, "R2 count after 8");
    // R4 disable clears and holds
    wr('h00, 'h102);
    rd('h10, 0, 0, "R4 cleared");
    idle(3);
    rd('h10, 0, 0, "R4 held");
    // R3 prescaler 3
    wr('h04, 3);
    wr('h00, 'h103);
    idle(8);
    rd('h10, 2, 0, "R3 prescale 2");
    idle(3);
    rd('h10, 3, 0, "R3 prescale 3");
    // R5/R6/R10 compare in free-run with interrupt
    wr('h00, 'h102);
    wr('h04, 0);
    wr('h08, 5);
    wr('h14, 3);
    wr('h00, 'h113);
    idle(4);
    rd('h14, 0, 0, "R5 before match");
    rd('h14, 1, 1, "R5 flag on match");
    rd('h10, 6, 1, "R6 past match");
    wr('h14, 1);
    rd('h14, 0, 0, "R9 clear cmp");
    idle(20);
    rd('h14, 0, 0, "R6 compare below count");
    // R7 restart mode, interrupt off
    wr('h00, 'h002);
    wr('h08, 3);
    wr('h14, 3);
    wr('h00, 'h003);
    idle(3);
    rd('h10, 3, 0, "R7 hold compare");
    rd('h10, 0, 0, "R7 reload zero");
    rd('h14, 1, 0, "R10 gated off");
    rd('h10, 2, 0, "R7 recount");
    wr('h00, 'h002);
    wr('h14, 0);
    rd('h14, 1, 0, "R9 zero ignored");
    wr('h14, 2);
    rd('h14, 1, 0, "R9 other bit kept");
    wr('h14, 1);
    rd('h14, 0, 0, "R9 cleared");
    // R8 capture
    wr('h08, 'hFFFF0000);
    wr('h00, 'h113);
    idle(4);
    capIn = 1'b1;
    idle(1);
    rd('h0C, 4, 1, "R8 capture value");
    rd('h14, 2, 1, "R8 capture flag");
    wr('h0C, 0);
    rd('h0C, 4, 1, "R8 read-only no recapture");
    capIn = 1'b0;
    wr('h14, 2);
    rd('h14, 0, 0, "R9 clear cap");
    // R2 external source
    wr('h00, 'h100);
    wr('h00, 'h101);
    idle(4);
    rd('h10, 0, 0, "R2 ext idle");
    extTick = 1'b1;
    idle(3);
    extTick = 1'b0;
    rd('h10, 3, 0, "R2 ext ticks");
    // R11 map
    rd('h04, 0, 0, "R11 prescale");
    rd('h08, 'hFFFF0000, 0, "R11 compare");
    rd('h18, 0, 0, "R11 unmapped");
    rd('h00, 'h101, 0, "R11 ctrl");
    idle(2);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule